// File: doc/BRIEF.md
# Priority-Based Reference Source Selector

This block decides which of several reference inputs feeds a downstream locking loop. Input 0 is the master, input 1 is the slave, and every higher-numbered input is a stand-by source. Each input arrives with a valid flag from an external qualifier and a 4-bit priority value. In normal operation the block picks the valid input whose priority is best. When that input fails, it moves to the next best input. When no input can be used, it requests holdover.

The block has two operating policies. In revertive mode, a better source that comes back is switched back to only after it has stayed the best candidate for a programmable number of qualification ticks. In non-revertive mode, the current source is kept for as long as it stays usable. An external-switching mode lets a force pin pick master or slave directly, ignoring the priority order. Every change of the selected channel produces a one-cycle pulse for a downstream phase build-out stage.

Top module: `ref_src_selector`

## Requirements
- R1: While reset is held, and until the first selection, the selected and best channel outputs read 4'hF, holdover is 1 and the switch pulse is 0.
- R2: In priority mode the block selects the eligible input with the numerically smallest priority. An input is eligible when its valid flag is 1 and its priority is non-zero. All outputs update on the first clock edge after the inputs change.
- R3: When two eligible inputs have equal priority, the lower channel number ranks first. A source with equal priority does not displace the current selection.
- R4: An input whose priority field is 0 is disabled. In priority mode it is never selected and never reported as best.
- R5: When the selected input stops being eligible, the next best eligible input is selected on the next edge. With master and slave both down, a stand-by input is selected.
- R6: With no usable input, the selected channel reads 4'hF and holdover reads 1.
- R7: In non-revertive mode an eligible current selection is kept, even when an input with better priority becomes eligible.
- R8: In revertive mode a better input replaces the current one only after it has been the best candidate for `restore_ticks` qualification ticks. With a limit of 0, the switch happens on the second edge after the input returns.
- R9: With external switching enabled, force_slave=0 selects channel 0 and force_slave=1 selects channel 1 whenever that input is valid, whatever its priority. If the forced input is invalid, the other input of the pair is used. If both are invalid, the best eligible stand-by input is used. If none is available, the block goes to holdover.
- R10: The status word carries the best eligible channel in bits [7:4] and the selected channel in bits [3:0].
- R11: The switch pulse is 1 for exactly the one cycle in which the selected channel output takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | N_SRC | Per-input valid flag from the qualifier |
| src_prio | input | N_SRC*PRIO_W | Packed priority fields; input i occupies bits [i*PRIO_W +: PRIO_W] |
| revertive | input | 1 | 1 = switch back to a restored better source after qualification |
| restore_ticks | input | TICK_W | Qualification ticks required before reverting |
| qual_tick | input | 1 | Qualification time-base strobe |
| ext_switch_en | input | 1 | Enables the external master/slave force |
| force_slave | input | 1 | Force pin: 0 = master, 1 = slave |
| sel_ch | output | CH_W | Selected channel, all-ones when nothing is selected |
| best_ch | output | CH_W | Best eligible channel, all-ones when none |
| status | output | 2*CH_W | {best_ch, sel_ch} |
| holdover | output | 1 | No source selected; the loop should hold |
| switch_pulse | output | 1 | One-cycle pulse on any change of sel_ch |

## Verification
The bench uses the defaults: three inputs (master, slave, one stand-by), 4-bit priority and channel fields, and an 8-bit tick counter. With these values the bench can reach every role: fallback to the stand-by, the forced pair and the disabled-priority case. The revert window is exercised with limits of 3 and 0. The limit of 3 shows that a switch happens on exactly the third tick and not earlier. The limit of 0 shows the two-edge minimum latency of a revert.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  // Smaller priority number ranks higher; equal values do not outrank.
  function automatic logic outranks(input logic [31:0] a, input logic [31:0] b);
    return a < b;
  endfunction

  // A priority field of zero disables the input.
  function automatic logic prio_enabled(input logic [31:0] p);
    return p != 32'd0;
  endfunction

endpackage

// File: rtl/ref_rank.sv
module ref_rank
  import refsel_pkg::*;
#(
  parameter int N_SRC  = 3,
  parameter int PRIO_W = 4,
  parameter int CH_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        elig,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    best_vld,
  output logic [CH_W-1:0]         best_ch
);

  logic [PRIO_W-1:0] prio_a [N_SRC];
  logic [PRIO_W-1:0] best_prio;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_unpack
    assign prio_a[gi] = prio_flat[gi*PRIO_W +: PRIO_W];
  end

  // Ascending scan: a strict compare keeps the lower index on ties.
  always_comb begin
    best_vld  = 1'b0;
    best_ch   = '1;
    best_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!best_vld || outranks(32'(prio_a[i]), 32'(best_prio)))) begin
        best_vld  = 1'b1;
        best_ch   = CH_W'(i);
        best_prio = prio_a[i];
      end
    end
  end

  logic pick_is_elig;
  always_comb begin
    pick_is_elig = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (best_ch == CH_W'(i)) pick_is_elig = elig[i];
  end

  // R2
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld |-> pick_is_elig);

endmodule

// File: rtl/ref_restore_timer.sv
module ref_restore_timer #(
  parameter int CH_W   = 4,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [CH_W-1:0]   cand_ch,
  input  logic              tick,
  input  logic [TICK_W-1:0] limit,
  output logic              done
);

  logic [CH_W-1:0]   cand_q;
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '1;
      cnt_q  <= '0;
    end else if (!arm) begin
      cand_q <= '1;
      cnt_q  <= '0;
    end else if (cand_q != cand_ch) begin
      cand_q <= cand_ch;
      cnt_q  <= '0;
    end else if (tick && (cnt_q != '1)) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = arm && (cand_q == cand_ch) && (cnt_q >= limit);

  // R8
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cand_q == cand_ch) |=> (cnt_q >= $past(cnt_q)) || !$past(arm) || (cand_q != $past(cand_q)));

endmodule

// File: rtl/ref_src_selector.sv
module ref_src_selector
  import refsel_pkg::*;
#(
  parameter int N_SRC  = 3,
  parameter int PRIO_W = 4,
  parameter int CH_W   = 4,
  parameter int TICK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_valid,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic                    revertive,
  input  logic [TICK_W-1:0]       restore_ticks,
  input  logic                    qual_tick,
  input  logic                    ext_switch_en,
  input  logic                    force_slave,
  output logic [CH_W-1:0]         sel_ch,
  output logic [CH_W-1:0]         best_ch,
  output logic [2*CH_W-1:0]       status,
  output logic                    holdover,
  output logic                    switch_pulse
);

  localparam int             PAIR    = 2;
  localparam logic [CH_W-1:0] CH_NONE = '1;

  logic [N_SRC-1:0] elig, rest_elig;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_elig
    assign elig[gi] = src_valid[gi] && prio_enabled(32'(src_prio[gi*PRIO_W +: PRIO_W]));
    if (gi >= PAIR) begin : g_rest
      assign rest_elig[gi] = elig[gi];
    end else begin : g_pair
      assign rest_elig[gi] = 1'b0;
    end
  end

  logic            best_vld, rest_vld;
  logic [CH_W-1:0] best_w, rest_w;

  ref_rank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_rank_all (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio_flat(src_prio),
    .best_vld(best_vld), .best_ch(best_w));

  ref_rank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_rank_rest (
    .clk(clk), .rst_n(rst_n), .elig(rest_elig), .prio_flat(src_prio),
    .best_vld(rest_vld), .best_ch(rest_w));

  logic [CH_W-1:0]   sel_q, best_q;
  logic              hold_q, pulse_q;
  logic              cur_ok;
  logic [PRIO_W-1:0] cur_prio, best_prio;

  always_comb begin
    cur_ok    = 1'b0;
    cur_prio  = '1;
    best_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_q == CH_W'(i)) begin
        cur_ok   = elig[i];
        cur_prio = src_prio[i*PRIO_W +: PRIO_W];
      end
      if (best_w == CH_W'(i)) best_prio = src_prio[i*PRIO_W +: PRIO_W];
    end
  end

  logic better_w, arm_w, revert_done;
  assign better_w = best_vld && cur_ok && outranks(32'(best_prio), 32'(cur_prio));
  assign arm_w    = !ext_switch_en && revertive && better_w;

  ref_restore_timer #(.CH_W(CH_W), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .cand_ch(best_w),
    .tick(qual_tick), .limit(restore_ticks), .done(revert_done));

  logic [CH_W-1:0] force_ch, other_ch;
  logic            force_vld, other_vld;
  assign force_ch  = force_slave ? CH_W'(1) : CH_W'(0);
  assign other_ch  = force_slave ? CH_W'(0) : CH_W'(1);
  assign force_vld = force_slave ? src_valid[1] : src_valid[0];
  assign other_vld = force_slave ? src_valid[0] : src_valid[1];

  logic [CH_W-1:0] nxt_sel;
  always_comb begin
    if (ext_switch_en) begin
      if (force_vld)      nxt_sel = force_ch;
      else if (other_vld) nxt_sel = other_ch;
      else if (rest_vld)  nxt_sel = rest_w;
      else                nxt_sel = CH_NONE;
    end else begin
      if (!best_vld)         nxt_sel = CH_NONE;
      else if (!cur_ok)      nxt_sel = best_w;
      else if (revert_done)  nxt_sel = best_w;
      else                   nxt_sel = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= CH_NONE;
      best_q  <= CH_NONE;
      hold_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      sel_q   <= nxt_sel;
      best_q  <= best_vld ? best_w : CH_NONE;
      hold_q  <= (nxt_sel == CH_NONE);
      pulse_q <= (nxt_sel != sel_q);
    end
  end

  assign sel_ch       = sel_q;
  assign best_ch      = best_q;
  assign status       = {best_q, sel_q};
  assign holdover     = hold_q;
  assign switch_pulse = pulse_q;

  // R11
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> pulse_q);

  // R11
  pulse_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (sel_q != $past(sel_q)));

  // R7
  nonrevert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_switch_en && !revertive && cur_ok) |=> (sel_q == $past(sel_q)));

  // R9
  force_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_switch_en && force_vld) |=> (sel_q == $past(force_ch)));

  // R6
  holdover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_switch_en && !best_vld) |=> (holdover && sel_q == CH_NONE));

endmodule

// File: tb/tb_ref_src_selector.sv
`timescale 1ns/1ps
module tb_ref_src_selector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_valid = '0;
  logic [11:0] src_prio = '0;
  logic        revertive = 1'b0;
  logic [7:0]  restore_ticks = 8'd0;
  logic        qual_tick = 1'b0;
  logic        ext_switch_en = 1'b0;
  logic        force_slave = 1'b0;
  logic [3:0]  sel_ch, best_ch;
  logic [7:0]  status;
  logic        holdover, switch_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ref_src_selector dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_prio(src_prio),
    .revertive(revertive), .restore_ticks(restore_ticks), .qual_tick(qual_tick),
    .ext_switch_en(ext_switch_en), .force_slave(force_slave),
    .sel_ch(sel_ch), .best_ch(best_ch), .status(status),
    .holdover(holdover), .switch_pulse(switch_pulse));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [3:0] es, input logic [3:0] eb);
    chk({req, " sel"}, {4'h0, sel_ch}, {4'h0, es});
    chk({req, " best"}, {4'h0, best_ch}, {4'h0, eb});
    chk({req, " holdover"}, {7'h0, holdover}, {7'h0, es == 4'hF});
    chk({req, " R10 status"}, status, {eb, es});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_prio(input logic [3:0] m, input logic [3:0] s, input logic [3:0] b);
    src_prio = {b, s, m};
  endtask

  task automatic pulse_tick();
    qual_tick = 1'b1;
    @(negedge clk);
    qual_tick = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk_state("R1 reset", 4'hF, 4'hF);
    chk("R1 pulse", {7'h0, switch_pulse}, 8'h0);
    rst_n = 1'b1;
    step(1);
    chk_state("R1 idle", 4'hF, 4'hF);
  endtask

  task automatic t_prio();
    set_prio(4'd3, 4'd2, 4'd5);
    src_valid = 3'b111;
    step(1);
    chk_state("R2 smallest wins", 4'd1, 4'd1);
    chk("R11 pulse high", {7'h0, switch_pulse}, 8'h1);
    step(1);
    chk("R11 pulse one cycle", {7'h0, switch_pulse}, 8'h0);
  endtask

  task automatic t_tie();
    set_prio(4'd2, 4'd2, 4'd5);
    step(1);
    chk_state("R3 equal no displace", 4'd1, 4'd0);
    src_valid = 3'b000;
    step(1);
    chk_state("R6 none usable", 4'hF, 4'hF);
    src_valid = 3'b111;
    step(1);
    chk_state("R3 tie lower index", 4'd0, 4'd0);
  endtask

  task automatic t_disable();
    set_prio(4'd0, 4'd2, 4'd5);
    step(1);
    chk_state("R4 disabled dropped", 4'd1, 4'd1);
    src_valid = 3'b001;
    step(1);
    chk_state("R4 disabled never picked", 4'hF, 4'hF);
  endtask

  task automatic t_failover();
    set_prio(4'd1, 4'd2, 4'd3);
    src_valid = 3'b110;
    step(1);
    chk_state("R5 pick slave", 4'd1, 4'd1);
    src_valid = 3'b111;
    step(3);
    chk_state("R7 nonrevert keep", 4'd1, 4'd0);
    src_valid = 3'b101;
    step(1);
    chk_state("R5 next best", 4'd0, 4'd0);
    src_valid = 3'b100;
    step(1);
    chk_state("R5 stand-by", 4'd2, 4'd2);
    src_valid = 3'b000;
    step(1);
    chk_state("R6 holdover", 4'hF, 4'hF);
  endtask

  task automatic t_revert();
    revertive = 1'b1;
    restore_ticks = 8'd3;
    src_valid = 3'b110;
    step(1);
    chk_state("R8 start slave", 4'd1, 4'd1);
    src_valid = 3'b111;
    step(3);
    chk_state("R8 no ticks yet", 4'd1, 4'd0);
    pulse_tick();
    pulse_tick();
    step(2);
    chk_state("R8 two ticks", 4'd1, 4'd0);
    pulse_tick();
    step(1);
    chk_state("R8 third tick reverts", 4'd0, 4'd0);
    chk("R11 revert pulse", {7'h0, switch_pulse}, 8'h1);
    restore_ticks = 8'd0;
    src_valid = 3'b110;
    step(1);
    chk_state("R8 master lost", 4'd1, 4'd1);
    src_valid = 3'b111;
    step(1);
    chk_state("R8 zero limit first edge", 4'd1, 4'd0);
    step(1);
    chk_state("R8 zero limit second edge", 4'd0, 4'd0);
    revertive = 1'b0;
  endtask

  task automatic t_ext();
    ext_switch_en = 1'b1;
    force_slave = 1'b0;
    set_prio(4'd5, 4'd1, 4'd3);
    src_valid = 3'b111;
    step(1);
    chk_state("R9 force master", 4'd0, 4'd1);
    force_slave = 1'b1;
    step(1);
    chk_state("R9 force slave", 4'd1, 4'd1);
    src_valid = 3'b101;
    step(1);
    chk_state("R9 other of pair", 4'd0, 4'd2);
    src_valid = 3'b100;
    step(1);
    chk_state("R9 stand-by", 4'd2, 4'd2);
    src_valid = 3'b000;
    step(1);
    chk_state("R9 holdover", 4'hF, 4'hF);
    force_slave = 1'b0;
    set_prio(4'd0, 4'd1, 4'd3);
    src_valid = 3'b001;
    step(1);
    chk_state("R9 bypass priority", 4'd0, 4'hF);
    ext_switch_en = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_prio();
    t_tie();
    t_disable();
    t_failover();
    t_revert();
    t_ext();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule